// File: doc/BRIEF.md
# Instruction fetch line requester

This block sits at the front of an in-order instruction pipeline. It turns a running fetch address into a stream of line-sized fetch requests and follows each one through address translation and the instruction memory. It then hands the returned lines downstream in the order they were generated. A redirect loads a new fetch address and starts the stream. From then on, one request is produced each cycle that translation accepts one and the in-flight budget allows it.

A generated request waits in an ordered requests queue until its translation returns. Only the oldest entry may leave. A translated entry is offered to memory, and once memory takes it the entry moves to an ordered transfers queue, where it waits for its response. A translation fault sends the entry straight to the transfers queue as a finished line marked faulty, with no memory access. Memory may refuse a request. After a refusal the port stays silent until a retry pulse arrives. Memory responses may return in any order because they are matched by sequence number. Delivery downstream still follows generation order.

Top module: `ifetch_line_req`

## Requirements
- R1: A request's address is the fetch address rounded down to a multiple of SNAP_BYTES. Its size in bytes is LINE_BYTES minus (that address modulo LINE_BYTES), so a request never crosses a LINE_BYTES boundary.
- R2: No request is made after reset until the first redirect, and none is made in a redirect cycle. After a redirect the first request uses the redirect address. After each accepted request the fetch address becomes request address plus request size.
- R3: The in-flight count is the number of entries in the requests and transfers queues. A request is offered only while this count is below FETCH_LIMIT, so the count never exceeds FETCH_LIMIT.
- R4: Sequence numbers start at 0 after reset and rise by one per accepted request, modulo 2^SEQ_W.
- R5: Only the oldest untransferred entry may be issued to memory, and only once its translation has returned. The issued request carries the translated address, the size and the sequence number.
- R6: A cycle with mem_req_valid high and mem_req_accept low puts the port into a retry state. In that state mem_req_valid stays low until the cycle after mem_retry is seen high.
- R7: An entry whose translation reports a fault is never issued to memory. It is delivered in its place in order with out_fault high.
- R8: Lines leave in sequence order whatever order the responses arrive in. out_valid rises only for a line whose response (or fault) is present. A line is removed only on out_valid && out_ready, and the offered line holds steady while out_ready is low.
- R9: After reset out_valid, mem_req_valid and xlat_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| redirect_valid | input | 1 | load a new fetch address and start fetching |
| redirect_addr | input | ADDR_W | new fetch address |
| xlat_req_valid | output | 1 | request offered to translation |
| xlat_req_ready | input | 1 | translation accepts the request |
| xlat_req_vaddr | output | ADDR_W | snap-aligned virtual address of the request |
| xlat_req_size | output | SIZE_W | request size in bytes |
| xlat_rsp_valid | input | 1 | translation result for the oldest untranslated entry |
| xlat_rsp_paddr | input | ADDR_W | translated address |
| xlat_rsp_fault | input | 1 | translation failed |
| mem_req_valid | output | 1 | request offered to memory |
| mem_req_accept | input | 1 | memory takes the request this cycle (low means refused) |
| mem_req_addr | output | ADDR_W | translated address |
| mem_req_size | output | SIZE_W | size in bytes |
| mem_req_seq | output | SEQ_W | sequence number |
| mem_retry | input | 1 | memory can take a refused request again |
| mem_rsp_valid | input | 1 | memory response |
| mem_rsp_seq | input | SEQ_W | sequence number of the response |
| mem_rsp_data | input | LINE_BYTES*8 | line data |
| out_valid | output | 1 | line offered downstream |
| out_ready | input | 1 | downstream accepts the line |
| out_vaddr | output | ADDR_W | virtual address of the line |
| out_size | output | SIZE_W | size in bytes |
| out_seq | output | SEQ_W | sequence number |
| out_fault | output | 1 | translation fault, data not valid |
| out_data | output | LINE_BYTES*8 | line data |

## Verification
xlat_req_valid and mem_req_valid are combinational on registered state and the current inputs. A redirect, a translation result or a memory acceptance therefore changes them in the cycle after the edge that captured it. A memory response or fault move shows on out_valid one cycle after the capturing edge. The retry state ends on the edge that sees mem_retry, so the next request can appear in the following cycle. The bench drives inputs on the falling edge, waits a short delay and then samples the combinational outputs, so every handshake is recorded in the cycle in which the next rising edge completes it. It compares each handshake against its own queue of expected lines, built from the address arithmetic in the requirements.

// File: rtl/ifl_pkg.sv
package ifl_pkg;

  typedef enum logic {
    PORT_RUN   = 1'b0,
    PORT_RETRY = 1'b1
  } port_state_e;

  // true when sequence a is strictly newer than b in a w-bit wrapping space
  function automatic logic seq_after(logic [31:0] a, logic [31:0] b, int unsigned w);
    logic [31:0] mask;
    logic [31:0] d;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d    = (a - b) & mask;
    return (d != 32'd0) && (d < (32'd1 << (w - 1)));
  endfunction

endpackage

// File: rtl/fr_addr_gen.sv
module fr_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int SNAP_BYTES = 16,
  parameter int LINE_BYTES = 32,
  parameter int SEQ_W      = 16,
  localparam int SIZE_W    = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              can_issue,
  input  logic              accept,
  output logic              req_valid,
  output logic              req_fire,
  output logic [ADDR_W-1:0] req_vaddr,
  output logic [SIZE_W-1:0] req_size,
  output logic [SEQ_W-1:0]  req_seq
);

  function automatic logic [ADDR_W-1:0] snap_base(logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(SNAP_BYTES - 1);
  endfunction

  function automatic logic [SIZE_W-1:0] room_in_line(logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] off;
    off = b & ADDR_W'(LINE_BYTES - 1);
    return SIZE_W'(LINE_BYTES) - off[SIZE_W-1:0];
  endfunction

  logic              running;
  logic [ADDR_W-1:0] fetch_addr;
  logic [SEQ_W-1:0]  seq_q;

  assign req_vaddr = snap_base(fetch_addr);
  assign req_size  = room_in_line(req_vaddr);
  assign req_seq   = seq_q;
  assign req_valid = running && !redirect_valid && can_issue;
  assign req_fire  = req_valid && accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      fetch_addr <= '0;
      seq_q      <= '0;
    end else if (redirect_valid) begin
      running    <= 1'b1;
      fetch_addr <= redirect_addr;
    end else if (req_fire) begin
      fetch_addr <= req_vaddr + {{(ADDR_W-SIZE_W){1'b0}}, req_size};
      seq_q      <= seq_q + 1'b1;
    end
  end

endmodule

// File: rtl/fr_req_queue.sv
module fr_req_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6,
  parameter int SEQ_W  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_vaddr,
  input  logic [SIZE_W-1:0] push_size,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic              xlat_valid,
  input  logic [ADDR_W-1:0] xlat_paddr,
  input  logic              xlat_fault,
  input  logic              pop,
  output logic              head_valid,
  output logic              head_translated,
  output logic              head_fault,
  output logic [ADDR_W-1:0] head_vaddr,
  output logic [ADDR_W-1:0] head_paddr,
  output logic [SIZE_W-1:0] head_size,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [CNT_W-1:0]  count
);

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ADDR_W-1:0] vaddr_q [DEPTH];
  logic [ADDR_W-1:0] paddr_q [DEPTH];
  logic [SIZE_W-1:0] size_q  [DEPTH];
  logic [SEQ_W-1:0]  seq_q   [DEPTH];
  logic [DEPTH-1:0]  fault_q;
  logic [DEPTH-1:0]  done_q;
  logic [PTR_W-1:0]  hd, tl, xp;

  assign head_valid      = (count != '0);
  assign head_translated = head_valid && done_q[hd];
  assign head_fault      = fault_q[hd];
  assign head_vaddr      = vaddr_q[hd];
  assign head_paddr      = paddr_q[hd];
  assign head_size       = size_q[hd];
  assign head_seq        = seq_q[hd];

  always_ff @(posedge clk) begin
    if (push) begin
      vaddr_q[tl] <= push_vaddr;
      size_q[tl]  <= push_size;
      seq_q[tl]   <= push_seq;
    end
    if (xlat_valid) begin
      paddr_q[xp] <= xlat_paddr;
      fault_q[xp] <= xlat_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd     <= '0;
      tl     <= '0;
      xp     <= '0;
      count  <= '0;
      done_q <= '0;
    end else begin
      if (push) begin
        done_q[tl] <= 1'b0;
        tl         <= step(tl);
      end
      if (xlat_valid) begin
        done_q[xp] <= 1'b1;
        xp         <= step(xp);
      end
      if (pop) hd <= step(hd);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/fr_xfer_queue.sv
module fr_xfer_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 256,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_done,
  input  logic [ADDR_W-1:0] push_vaddr,
  input  logic [SIZE_W-1:0] push_size,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic              rsp_valid,
  input  logic [SEQ_W-1:0]  rsp_seq,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              pop,
  output logic              head_ready,
  output logic              head_fault,
  output logic [ADDR_W-1:0] head_vaddr,
  output logic [SIZE_W-1:0] head_size,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count
);

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ADDR_W-1:0] vaddr_q [DEPTH];
  logic [SIZE_W-1:0] size_q  [DEPTH];
  logic [SEQ_W-1:0]  seq_q   [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [DEPTH-1:0]  fault_q;
  logic [DEPTH-1:0]  live_q;
  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  hit;
  logic [PTR_W-1:0]  hd, tl;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign hit[i] = rsp_valid && live_q[i] && !done_q[i] && (seq_q[i] == rsp_seq);
  end

  assign head_ready = (count != '0) && done_q[hd];
  assign head_fault = fault_q[hd];
  assign head_vaddr = vaddr_q[hd];
  assign head_size  = size_q[hd];
  assign head_seq   = seq_q[hd];
  assign head_data  = data_q[hd];

  always_ff @(posedge clk) begin
    if (push) begin
      vaddr_q[tl] <= push_vaddr;
      size_q[tl]  <= push_size;
      seq_q[tl]   <= push_seq;
      fault_q[tl] <= push_done;
      data_q[tl]  <= '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) data_q[i] <= rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd     <= '0;
      tl     <= '0;
      count  <= '0;
      live_q <= '0;
      done_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i]) done_q[i] <= 1'b1;
      end
      if (pop) begin
        live_q[hd] <= 1'b0;
        hd         <= step(hd);
      end
      if (push) begin
        live_q[tl] <= 1'b1;
        done_q[tl] <= push_done;
        tl         <= step(tl);
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/ifetch_line_req.sv
module ifetch_line_req
  import ifl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SNAP_BYTES  = 16,
  parameter int LINE_BYTES  = 32,
  parameter int INST_BYTES  = 4,
  parameter int FETCH_LIMIT = 4,
  parameter int SEQ_W       = 16,
  localparam int SIZE_W     = $clog2(LINE_BYTES) + 1,
  localparam int DATA_W     = LINE_BYTES * 8,
  localparam int CNT_W      = $clog2(FETCH_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  output logic              xlat_req_valid,
  input  logic              xlat_req_ready,
  output logic [ADDR_W-1:0] xlat_req_vaddr,
  output logic [SIZE_W-1:0] xlat_req_size,
  input  logic              xlat_rsp_valid,
  input  logic [ADDR_W-1:0] xlat_rsp_paddr,
  input  logic              xlat_rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_accept,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  output logic [SEQ_W-1:0]  mem_req_seq,
  input  logic              mem_retry,
  input  logic              mem_rsp_valid,
  input  logic [SEQ_W-1:0]  mem_rsp_seq,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_vaddr,
  output logic [SIZE_W-1:0] out_size,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_fault,
  output logic [DATA_W-1:0] out_data
);

  // named internal events, observed by the bound checker
  logic [CNT_W:0]  inflight;
  logic            can_issue;
  logic            gen_fire;
  logic            port_retry;
  logic            fault_move;
  logic            mem_sent;
  logic            mem_refused;
  logic            head_leave;

  logic [CNT_W-1:0]  rq_count, xq_count;
  logic              rq_valid, rq_translated, rq_fault;
  logic [ADDR_W-1:0] rq_vaddr, rq_paddr;
  logic [SIZE_W-1:0] rq_size;
  logic [SEQ_W-1:0]  rq_seq;
  logic [SEQ_W-1:0]  gen_seq;
  port_state_e       port_q;

  assign inflight  = {1'b0, rq_count} + {1'b0, xq_count};
  assign can_issue = inflight < (CNT_W + 1)'(FETCH_LIMIT);

  fr_addr_gen #(
    .ADDR_W(ADDR_W), .SNAP_BYTES(SNAP_BYTES), .LINE_BYTES(LINE_BYTES), .SEQ_W(SEQ_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .can_issue(can_issue), .accept(xlat_req_ready),
    .req_valid(xlat_req_valid), .req_fire(gen_fire),
    .req_vaddr(xlat_req_vaddr), .req_size(xlat_req_size), .req_seq(gen_seq)
  );

  fr_req_queue #(
    .DEPTH(FETCH_LIMIT), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEQ_W(SEQ_W)
  ) u_rq (
    .clk(clk), .rst_n(rst_n),
    .push(gen_fire), .push_vaddr(xlat_req_vaddr), .push_size(xlat_req_size),
    .push_seq(gen_seq),
    .xlat_valid(xlat_rsp_valid), .xlat_paddr(xlat_rsp_paddr), .xlat_fault(xlat_rsp_fault),
    .pop(head_leave),
    .head_valid(rq_valid), .head_translated(rq_translated), .head_fault(rq_fault),
    .head_vaddr(rq_vaddr), .head_paddr(rq_paddr), .head_size(rq_size),
    .head_seq(rq_seq), .count(rq_count)
  );

  assign port_retry    = (port_q == PORT_RETRY);
  assign fault_move    = rq_translated && rq_fault;
  assign mem_req_valid = rq_translated && !rq_fault && !port_retry;
  assign mem_req_addr  = rq_paddr;
  assign mem_req_size  = rq_size;
  assign mem_req_seq   = rq_seq;
  assign mem_sent      = mem_req_valid && mem_req_accept;
  assign mem_refused   = mem_req_valid && !mem_req_accept;
  assign head_leave    = mem_sent || fault_move;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= PORT_RUN;
    end else begin
      unique case (port_q)
        PORT_RUN:   if (mem_refused) port_q <= PORT_RETRY;
        PORT_RETRY: if (mem_retry)   port_q <= PORT_RUN;
        default:    port_q <= PORT_RUN;
      endcase
    end
  end

  logic xq_ready;

  fr_xfer_queue #(
    .DEPTH(FETCH_LIMIT), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
  ) u_xq (
    .clk(clk), .rst_n(rst_n),
    .push(head_leave), .push_done(fault_move),
    .push_vaddr(rq_vaddr), .push_size(rq_size), .push_seq(rq_seq),
    .rsp_valid(mem_rsp_valid), .rsp_seq(mem_rsp_seq), .rsp_data(mem_rsp_data),
    .pop(out_valid && out_ready),
    .head_ready(xq_ready), .head_fault(out_fault),
    .head_vaddr(out_vaddr), .head_size(out_size), .head_seq(out_seq),
    .head_data(out_data), .count(xq_count)
  );

  assign out_valid = xq_ready;

endmodule

// File: rtl/ifetch_line_req_chk.sv
module ifetch_line_req_chk
  import ifl_pkg::*;
#(
  parameter int SNAP_BYTES  = 16,
  parameter int LINE_BYTES  = 32,
  parameter int INST_BYTES  = 4,
  parameter int FETCH_LIMIT = 4,
  parameter int SEQ_W       = 16,
  parameter int INF_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xlat_req_valid,
  input logic             mem_req_valid,
  input logic             mem_req_accept,
  input logic             mem_retry,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SEQ_W-1:0] out_seq,
  input logic [INF_W-1:0] inflight,
  input logic             port_retry
);

  logic [SEQ_W-1:0] last_seq;
  logic             have_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_seq  <= '0;
      have_last <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_seq  <= out_seq;
      have_last <= 1'b1;
    end
  end

  initial begin
    a_params_legal: assert (FETCH_LIMIT >= 1 && LINE_BYTES >= SNAP_BYTES &&
                            (SNAP_BYTES % INST_BYTES) == 0 && (LINE_BYTES % INST_BYTES) == 0 &&
                            (LINE_BYTES % SNAP_BYTES) == 0);
  end

  a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= INF_W'(FETCH_LIMIT));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req_valid |-> inflight < INF_W'(FETCH_LIMIT));

  a_r6_enter_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_accept) |=> port_retry);

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (port_retry && !mem_retry) |=> !mem_req_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq)));

  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_last) |->
      (seq_after(32'(out_seq), 32'(last_seq), SEQ_W) && out_seq == SEQ_W'(last_seq + 1'b1)));

endmodule

bind ifetch_line_req ifetch_line_req_chk #(
  .SNAP_BYTES(SNAP_BYTES), .LINE_BYTES(LINE_BYTES), .INST_BYTES(INST_BYTES),
  .FETCH_LIMIT(FETCH_LIMIT), .SEQ_W(SEQ_W), .INF_W(CNT_W + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .xlat_req_valid(xlat_req_valid), .mem_req_valid(mem_req_valid),
  .mem_req_accept(mem_req_accept), .mem_retry(mem_retry),
  .out_valid(out_valid), .out_ready(out_ready), .out_seq(out_seq),
  .inflight(inflight), .port_retry(port_retry)
);

// File: tb/ifetch_line_req_tb.sv
module ifetch_line_req_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 32;
  localparam int SNAP  = 16;
  localparam int LINE  = 32;
  localparam int LIMIT = 4;
  localparam int SQW   = 4;
  localparam int SZW   = $clog2(LINE) + 1;
  localparam int DW    = LINE * 8;
  localparam logic [31:0] OFS = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect_valid = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic xlat_req_valid, xlat_req_ready = 1'b0;
  logic [AW-1:0] xlat_req_vaddr;
  logic [SZW-1:0] xlat_req_size;
  logic xlat_rsp_valid = 1'b0, xlat_rsp_fault = 1'b0;
  logic [AW-1:0] xlat_rsp_paddr = '0;
  logic mem_req_valid, mem_req_accept = 1'b1, mem_retry = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [SZW-1:0] mem_req_size;
  logic [SQW-1:0] mem_req_seq;
  logic mem_rsp_valid = 1'b0;
  logic [SQW-1:0] mem_rsp_seq = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic out_valid, out_ready = 1'b0, out_fault;
  logic [AW-1:0] out_vaddr;
  logic [SZW-1:0] out_size;
  logic [SQW-1:0] out_seq;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_line_req #(
    .ADDR_W(AW), .SNAP_BYTES(SNAP), .LINE_BYTES(LINE), .INST_BYTES(4),
    .FETCH_LIMIT(LIMIT), .SEQ_W(SQW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .xlat_req_valid(xlat_req_valid), .xlat_req_ready(xlat_req_ready),
    .xlat_req_vaddr(xlat_req_vaddr), .xlat_req_size(xlat_req_size),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_rsp_paddr(xlat_rsp_paddr),
    .xlat_rsp_fault(xlat_rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_accept(mem_req_accept),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_seq(mem_req_seq),
    .mem_retry(mem_retry),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_seq(mem_rsp_seq), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_vaddr(out_vaddr),
    .out_size(out_size), .out_seq(out_seq), .out_fault(out_fault), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mkdata(logic [31:0] pa);
    return {8{pa ^ 32'hA5A5_0000}};
  endfunction

  // knobs written by tasks on the rising edge, read by the model on the falling edge
  int  budget = 0;
  bit  redir_pend = 0;
  logic [31:0] redir_a = '0;
  logic [31:0] flt_lo = '0, flt_hi = '0;
  int  refuse_left = 0;
  bit  retry_pend = 0;
  bit  rsp_go = 1;
  bit  rsp_rev = 0;
  int  rsp_every = 1;
  int  rdy_mode = 0;

  // model state
  bit  started = 0;
  bit  model_retry = 0;
  int  refusals = 0;
  logic [31:0] exp_fa = '0;
  int  exp_seq = 0;
  int  gen_cnt = 0, out_cnt = 0, cyc = 0;
  logic [31:0] tlb_a [16];
  int  tlb_n = 0;
  logic [SQW-1:0] mq_s [16];
  logic [31:0]    mq_a [16];
  int  mq_n = 0;
  int  mem_idx = 0;
  logic [31:0] eq_a [16];
  logic [SZW-1:0] eq_sz [16];
  logic [SQW-1:0] eq_s [16];
  bit  eq_f [16];
  bit  eq_iss [16];
  bit  eq_rsp [16];
  int  eq_n = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      redirect_valid = 0; xlat_req_ready = 0; xlat_rsp_valid = 0;
      mem_retry = 0; mem_rsp_valid = 0; out_ready = 0; mem_req_accept = 1;
    end else begin
      cyc++;
      redirect_valid = redir_pend;
      redirect_addr  = redir_a;
      redir_pend     = 0;
      xlat_req_ready = (budget > 0);
      xlat_rsp_valid = (tlb_n > 0);
      if (tlb_n > 0) begin
        xlat_rsp_paddr = tlb_a[0] + OFS;
        xlat_rsp_fault = (tlb_a[0] >= flt_lo) && (tlb_a[0] < flt_hi);
      end
      mem_req_accept = (refuse_left == 0);
      mem_retry      = retry_pend;
      mem_rsp_valid  = 0;
      if (rsp_go && mq_n > 0 && (cyc % rsp_every) == 0) begin
        mem_idx       = rsp_rev ? mq_n - 1 : 0;
        mem_rsp_valid = 1;
        mem_rsp_seq   = mq_s[mem_idx];
        mem_rsp_data  = mkdata(mq_a[mem_idx]);
      end
      out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
      #1;
      if (redirect_valid) begin
        chk(!xlat_req_valid, "R2", "request in redirect cycle", 64'(xlat_req_valid), 0);
        exp_fa  = redirect_addr;
        started = 1;
      end
      if (xlat_req_valid && !started)
        chk(0, "R2", "request before first redirect", 1, 0);
      if (xlat_req_valid && xlat_req_ready) begin
        logic [31:0] base;
        logic [SZW-1:0] sz;
        base = exp_fa & ~32'(SNAP - 1);
        sz   = SZW'(LINE - int'(base & 32'(LINE - 1)));
        chk(xlat_req_vaddr == base, "R1 R2", "request address", 64'(xlat_req_vaddr), 64'(base));
        chk(xlat_req_size == sz, "R1", "request size", 64'(xlat_req_size), 64'(sz));
        chk(eq_n < LIMIT, "R3", "in-flight below limit at request", 64'(eq_n), LIMIT);
        exp_fa = base + 32'(sz);
        eq_a[eq_n] = base; eq_sz[eq_n] = sz; eq_s[eq_n] = SQW'(exp_seq);
        eq_f[eq_n] = (base >= flt_lo) && (base < flt_hi);
        eq_iss[eq_n] = 0; eq_rsp[eq_n] = 0;
        eq_n++;
        exp_seq++;
        tlb_a[tlb_n] = base; tlb_n++;
        budget--; gen_cnt++;
      end
      if (xlat_rsp_valid) begin
        for (int i = 1; i < tlb_n; i++) tlb_a[i-1] = tlb_a[i];
        tlb_n--;
      end
      if (mem_req_valid) begin
        int k;
        bit older_ok;
        k = -1;
        for (int i = 0; i < eq_n; i++) if (k < 0 && eq_s[i] == mem_req_seq && !eq_iss[i]) k = i;
        chk(!model_retry, "R6", "request while waiting for retry", 1, 0);
        chk(k >= 0, "R5", "issued sequence is pending", 64'(mem_req_seq), 0);
        if (k >= 0) begin
          older_ok = 1;
          for (int j = 0; j < k; j++) if (!eq_iss[j] && !eq_f[j]) older_ok = 0;
          chk(older_ok, "R5", "older entry bypassed", 64'(k), 0);
          chk(mem_req_addr == eq_a[k] + OFS, "R5", "translated address", 64'(mem_req_addr), 64'(eq_a[k] + OFS));
          chk(mem_req_size == eq_sz[k], "R5", "issued size", 64'(mem_req_size), 64'(eq_sz[k]));
          chk(!eq_f[k], "R7", "faulted entry sent to memory", 1, 0);
          if (mem_req_accept) begin
            eq_iss[k] = 1;
            mq_s[mq_n] = mem_req_seq; mq_a[mq_n] = mem_req_addr; mq_n++;
          end else begin
            refuse_left--; refusals++;
            model_retry = 1;
          end
        end
      end
      if (mem_retry) begin
        model_retry = 0;
        retry_pend  = 0;
      end
      if (mem_rsp_valid) begin
        for (int i = 0; i < eq_n; i++) if (eq_s[i] == mem_rsp_seq && eq_iss[i]) eq_rsp[i] = 1;
        for (int i = mem_idx + 1; i < mq_n; i++) begin mq_s[i-1] = mq_s[i]; mq_a[i-1] = mq_a[i]; end
        mq_n--;
      end
      if (out_valid) begin
        chk(eq_n > 0 && (eq_f[0] || eq_rsp[0]), "R8", "line offered before its response", 64'(out_seq), 0);
      end
      if (out_valid && out_ready && eq_n > 0) begin
        chk(out_seq == eq_s[0], "R4 R8", "delivered sequence", 64'(out_seq), 64'(eq_s[0]));
        chk(out_vaddr == eq_a[0], "R8", "delivered address", 64'(out_vaddr), 64'(eq_a[0]));
        chk(out_size == eq_sz[0], "R8", "delivered size", 64'(out_size), 64'(eq_sz[0]));
        chk(out_fault == eq_f[0], "R7", "fault flag", 64'(out_fault), 64'(eq_f[0]));
        if (!eq_f[0])
          chk(out_data == mkdata(eq_a[0] + OFS), "R8", "line data", out_data[63:0], mkdata(eq_a[0] + OFS)[63:0]);
        for (int i = 1; i < eq_n; i++) begin
          eq_a[i-1] = eq_a[i]; eq_sz[i-1] = eq_sz[i]; eq_s[i-1] = eq_s[i];
          eq_f[i-1] = eq_f[i]; eq_iss[i-1] = eq_iss[i]; eq_rsp[i-1] = eq_rsp[i];
        end
        eq_n--;
        out_cnt++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic redirect_to(logic [31:0] a, int n);
    @(posedge clk);
    redir_a = a; redir_pend = 1;
    @(posedge clk);
    budget = n;
  endtask

  task automatic drain(string req, int n_expected, int start_out);
    int t;
    t = 0;
    while ((budget > 0 || eq_n > 0) && t < 3000) begin @(posedge clk); t++; end
    chk(t < 3000, req, "stream did not drain", 64'(eq_n), 0);
    chk(out_cnt - start_out == n_expected, req, "lines delivered", 64'(out_cnt - start_out), 64'(n_expected));
  endtask

  task automatic t_reset();
    budget = 2;
    @(posedge clk); #1;
    chk(!out_valid, "R9", "out_valid after reset", 64'(out_valid), 0);
    chk(!mem_req_valid, "R9", "mem_req_valid after reset", 64'(mem_req_valid), 0);
    chk(!xlat_req_valid, "R9", "xlat_req_valid after reset", 64'(xlat_req_valid), 0);
    repeat (5) @(posedge clk);
    chk(gen_cnt == 0, "R2", "no request before redirect", 64'(gen_cnt), 0);
    budget = 0;
  endtask

  task automatic t_stream();
    int s;
    s = out_cnt;
    redirect_to(32'h0000_1000, 6);
    drain("R1", 6, s);
  endtask

  task automatic t_unaligned();
    int s;
    s = out_cnt;
    redirect_to(32'h0000_2014, 3);
    drain("R2", 3, s);
    s = out_cnt;
    redirect_to(32'h0000_3004, 2);
    drain("R1", 2, s);
  endtask

  task automatic t_limit();
    int s, g;
    s = out_cnt; g = gen_cnt;
    rsp_go = 0;
    redirect_to(32'h0000_5000, 10);
    repeat (15) @(posedge clk);
    chk(gen_cnt - g == LIMIT, "R3", "requests while memory silent", 64'(gen_cnt - g), LIMIT);
    rsp_go = 1;
    drain("R3", 10, s);
  endtask

  task automatic t_refuse();
    int s, t;
    s = out_cnt; t = 0;
    refuse_left = 1;
    redirect_to(32'h0000_6000, 3);
    while (!model_retry && t < 200) begin @(posedge clk); t++; end
    chk(model_retry, "R6", "refusal seen", 64'(refusals), 1);
    repeat (6) @(posedge clk);
    chk(model_retry, "R6", "still waiting for retry", 64'(model_retry), 1);
    retry_pend = 1;
    drain("R6", 3, s);
  endtask

  task automatic t_fault();
    int s;
    s = out_cnt;
    flt_lo = 32'h0000_4020; flt_hi = 32'h0000_4040;
    redirect_to(32'h0000_4000, 4);
    drain("R7", 4, s);
    flt_lo = '0; flt_hi = '0;
  endtask

  task automatic t_reorder();
    int s;
    s = out_cnt;
    rsp_rev = 1; rsp_every = 4; rdy_mode = 1;
    redirect_to(32'h0000_7008, 20);
    drain("R8", 20, s);
    rsp_rev = 0; rsp_every = 1; rdy_mode = 0;
  endtask

  task automatic t_wrap();
    int s;
    s = out_cnt;
    chk(exp_seq > (1 << SQW), "R4", "sequence has wrapped", 64'(exp_seq), 64'(1 << SQW));
    redirect_to(32'h0000_8010, 5);
    drain("R4", 5, s);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream();
    t_unaligned();
    t_limit();
    t_refuse();
    t_fault();
    t_reorder();
    t_wrap();
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule